// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level page table that lives in memory. A root base input gives the location of the top-level directory. The walker reads one directory entry and then one leaf entry through a single memory request port, and it checks the access rights. If the leaf entry's bookkeeping flags must change, it writes the entry back. It then returns either the translated address or a fault with a cause code. There is no translation cache, so every request performs a full walk.

Requests and responses each use a valid/ready handshake, and only one walk is in flight at a time. The memory port issues one access at a time. Each access is held until the memory side accepts it. A read returns one data word on a response strobe, and a write gets no reply. A separate register holds the virtual address and cause of the most recent fault.

Top module: `ptw_walker`

## Requirements
- R1: The directory entry is read at root_base + 4 × vaddr[31:22]. The leaf entry is read at {directory entry[31:12], 12'h000} + 4 × vaddr[21:12]. Entries are 32 bits.
- R2: On success rsp_fault is 0, rsp_cause is 0, and rsp_paddr = {leaf entry[31:12], vaddr[11:0]}.
- R3: If bit 0 (present) is clear in the directory entry or in the leaf entry, the response is a fault with cause 1. When the directory entry is absent, no leaf read is made.
- R4: A write request faults with cause 2 unless bit 1 (writable) is set in both the directory entry and the leaf entry.
- R5: A user-mode request faults with cause 3 unless bit 2 (user) is set in both entries. When a request breaks both rules, cause 2 is reported.
- R6: After a successful access, the leaf entry in memory has bit 5 (accessed) set. After a successful write it also has bit 6 (dirty) set. Both flags are written back by one memory write, which completes before the response is offered.
- R7: The leaf entry is written back only when its value changes. A faulting walk writes nothing to memory.
- R8: On each fault, fault_addr takes the request's virtual address and fault_cause takes the cause. Both keep their values through later successful walks.
- R9: req_ready is low from the moment a request is accepted until its response has been accepted. While rsp_valid is high and rsp_ready is low, the response holds steady.
- R10: While mem_req_ready is low, a memory request holds its valid, address, write flag and data steady.
- R11: After reset, req_ready is 1, and rsp_valid, mem_req_valid, fault_addr and fault_cause are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| root_base | input | 32 | Physical base address of the directory |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request can be accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a write access |
| req_user | input | 1 | Request comes from user mode |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_cause | output | 2 | 0 none, 1 not present, 2 write, 3 user |
| rsp_paddr | output | 32 | Translated physical address |
| mem_req_valid | output | 1 | Memory access valid |
| mem_req_ready | input | 1 | Memory accepts the access |
| mem_req_write | output | 1 | Access is a write-back |
| mem_req_addr | output | 32 | Entry address |
| mem_req_wdata | output | 32 | Write-back entry value |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| fault_addr | output | 32 | Virtual address of the last fault |
| fault_cause | output | 2 | Cause code of the last fault |

## Verification
The bench targets these corner cases:
- A walk whose leaf flags are already set. A walker that always writes back would issue an extra memory write, and the write counter would catch it.
- A write through a directory entry that forbids writes while its leaf allows them. The same test is run for the user flag. A design that checks only the leaf would translate these accesses when it should fault.
- A user write to a kernel read-only page. This shows whether the write cause wins.
- The highest directory and table index with the highest offset. Truncated index arithmetic would send the read to the wrong entry.
- Stalls on both the memory port and the response port. These expose a walker that changes its outputs before they are taken, or that loses its place in the walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   // Entry flag bit positions
   localparam int FLG_P = 0;
   localparam int FLG_W = 1;
   localparam int FLG_U = 2;
   localparam int FLG_A = 5;
   localparam int FLG_D = 6;

   typedef enum logic [1:0] {
      CAUSE_NONE   = 2'd0,
      CAUSE_ABSENT = 2'd1,
      CAUSE_WRITE  = 2'd2,
      CAUSE_USER   = 2'd3
   } ptw_cause_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DIR_REQ,
      ST_DIR_WAIT,
      ST_LEAF_REQ,
      ST_LEAF_WAIT,
      ST_CHECK,
      ST_WB,
      ST_RSP
   } ptw_state_e;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int PA_W        = 32,
   parameter int LVL_BITS    = 10,
   parameter int OFF_BITS    = 12,
   parameter int ENTRY_BYTES = 4
) (
   input  logic [PA_W-1:0]            root_base,
   input  logic [2*LVL_BITS+OFF_BITS-1:0] vaddr,
   input  logic [PA_W-OFF_BITS-1:0]   dir_frame,
   input  logic [PA_W-OFF_BITS-1:0]   leaf_frame,
   output logic [PA_W-1:0]            dir_addr,
   output logic [PA_W-1:0]            leaf_addr,
   output logic [PA_W-1:0]            paddr
);
   localparam int VA_W        = 2*LVL_BITS + OFF_BITS;
   localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

   logic [LVL_BITS-1:0] dir_idx;
   logic [LVL_BITS-1:0] leaf_idx;

   assign dir_idx  = vaddr[VA_W-1 -: LVL_BITS];
   assign leaf_idx = vaddr[OFF_BITS +: LVL_BITS];

   assign dir_addr  = root_base + (PA_W'(dir_idx) << ENTRY_SHIFT);
   assign leaf_addr = {dir_frame, {OFF_BITS{1'b0}}} + (PA_W'(leaf_idx) << ENTRY_SHIFT);
   assign paddr     = {leaf_frame, vaddr[OFF_BITS-1:0]};

endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
   import ptw_pkg::*;
#(
   parameter int ENTRY_W        = 32,
   parameter bit COMBINE_LEVELS = 1'b1
) (
   input  logic               dir_w,
   input  logic               dir_u,
   input  logic [ENTRY_W-1:0] leaf_entry,
   input  logic               is_write,
   input  logic               is_user,
   output ptw_cause_e         cause,
   output logic [ENTRY_W-1:0] leaf_next,
   output logic               need_wb
);
   logic w_ok;
   logic u_ok;

   generate
      if (COMBINE_LEVELS) begin : g_both_levels
         assign w_ok = dir_w & leaf_entry[FLG_W];
         assign u_ok = dir_u & leaf_entry[FLG_U];
      end else begin : g_leaf_only
         assign w_ok = leaf_entry[FLG_W];
         assign u_ok = leaf_entry[FLG_U];
      end
   endgenerate

   always_comb begin
      cause = CAUSE_NONE;
      if (!leaf_entry[FLG_P])
         cause = CAUSE_ABSENT;
      else if (is_write && !w_ok)
         cause = CAUSE_WRITE;
      else if (is_user && !u_ok)
         cause = CAUSE_USER;
   end

   always_comb begin
      leaf_next        = leaf_entry;
      leaf_next[FLG_A] = 1'b1;
      if (is_write)
         leaf_next[FLG_D] = 1'b1;
   end

   assign need_wb = (cause == CAUSE_NONE) && (leaf_next != leaf_entry);

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int PA_W           = 32,
   parameter int LVL_BITS       = 10,
   parameter int OFF_BITS       = 12,
   parameter int ENTRY_BYTES    = 4,
   parameter bit COMBINE_LEVELS = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [PA_W-1:0]                root_base,
   input  logic                           req_valid,
   output logic                           req_ready,
   input  logic [2*LVL_BITS+OFF_BITS-1:0] req_vaddr,
   input  logic                           req_write,
   input  logic                           req_user,
   output logic                           rsp_valid,
   input  logic                           rsp_ready,
   output logic                           rsp_fault,
   output logic [1:0]                     rsp_cause,
   output logic [PA_W-1:0]                rsp_paddr,
   output logic                           mem_req_valid,
   input  logic                           mem_req_ready,
   output logic                           mem_req_write,
   output logic [PA_W-1:0]                mem_req_addr,
   output logic [8*ENTRY_BYTES-1:0]       mem_req_wdata,
   input  logic                           mem_rsp_valid,
   input  logic [8*ENTRY_BYTES-1:0]       mem_rsp_rdata,
   output logic [2*LVL_BITS+OFF_BITS-1:0] fault_addr,
   output logic [1:0]                     fault_cause
);
   localparam int VA_W    = 2*LVL_BITS + OFF_BITS;
   localparam int ENTRY_W = 8*ENTRY_BYTES;
   localparam int FRAME_W = PA_W - OFF_BITS;

   initial begin : param_checks
      assert (ENTRY_W >= PA_W)
         else $error("entry narrower than physical address");
      assert (OFF_BITS > FLG_D)
         else $error("offset too small to hold the flag field");
      assert ((1 << $clog2(ENTRY_BYTES)) == ENTRY_BYTES)
         else $error("entry size must be a power of two");
   end

   ptw_state_e           state_q;
   logic [VA_W-1:0]      vaddr_q;
   logic                 write_q;
   logic                 user_q;
   logic [FRAME_W-1:0]   dir_frame_q;
   logic                 dir_w_q;
   logic                 dir_u_q;
   logic [ENTRY_W-1:0]   leaf_q;
   logic [PA_W-1:0]      rsp_paddr_q;
   logic                 rsp_fault_q;
   ptw_cause_e           rsp_cause_q;
   logic [VA_W-1:0]      fault_addr_q;
   ptw_cause_e           fault_cause_q;

   logic [PA_W-1:0]      dir_addr;
   logic [PA_W-1:0]      leaf_addr;
   logic [PA_W-1:0]      paddr;
   ptw_cause_e           chk_cause;
   logic [ENTRY_W-1:0]   leaf_next;
   logic                 need_wb;

   ptw_addr_gen #(
      .PA_W        (PA_W),
      .LVL_BITS    (LVL_BITS),
      .OFF_BITS    (OFF_BITS),
      .ENTRY_BYTES (ENTRY_BYTES)
   ) addr_gen_i (
      .root_base  (root_base),
      .vaddr      (vaddr_q),
      .dir_frame  (dir_frame_q),
      .leaf_frame (leaf_q[PA_W-1:OFF_BITS]),
      .dir_addr   (dir_addr),
      .leaf_addr  (leaf_addr),
      .paddr      (paddr)
   );

   ptw_perm_check #(
      .ENTRY_W        (ENTRY_W),
      .COMBINE_LEVELS (COMBINE_LEVELS)
   ) perm_check_i (
      .dir_w      (dir_w_q),
      .dir_u      (dir_u_q),
      .leaf_entry (leaf_q),
      .is_write   (write_q),
      .is_user    (user_q),
      .cause      (chk_cause),
      .leaf_next  (leaf_next),
      .need_wb    (need_wb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         vaddr_q       <= '0;
         write_q       <= 1'b0;
         user_q        <= 1'b0;
         dir_frame_q   <= '0;
         dir_w_q       <= 1'b0;
         dir_u_q       <= 1'b0;
         leaf_q        <= '0;
         rsp_paddr_q   <= '0;
         rsp_fault_q   <= 1'b0;
         rsp_cause_q   <= CAUSE_NONE;
         fault_addr_q  <= '0;
         fault_cause_q <= CAUSE_NONE;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  vaddr_q <= req_vaddr;
                  write_q <= req_write;
                  user_q  <= req_user;
                  state_q <= ST_DIR_REQ;
               end
            end
            ST_DIR_REQ: begin
               if (mem_req_ready) state_q <= ST_DIR_WAIT;
            end
            ST_DIR_WAIT: begin
               if (mem_rsp_valid) begin
                  dir_frame_q <= mem_rsp_rdata[PA_W-1:OFF_BITS];
                  dir_w_q     <= mem_rsp_rdata[FLG_W];
                  dir_u_q     <= mem_rsp_rdata[FLG_U];
                  if (!mem_rsp_rdata[FLG_P]) begin
                     rsp_fault_q   <= 1'b1;
                     rsp_cause_q   <= CAUSE_ABSENT;
                     rsp_paddr_q   <= '0;
                     fault_addr_q  <= vaddr_q;
                     fault_cause_q <= CAUSE_ABSENT;
                     state_q       <= ST_RSP;
                  end else begin
                     state_q <= ST_LEAF_REQ;
                  end
               end
            end
            ST_LEAF_REQ: begin
               if (mem_req_ready) state_q <= ST_LEAF_WAIT;
            end
            ST_LEAF_WAIT: begin
               if (mem_rsp_valid) begin
                  leaf_q  <= mem_rsp_rdata;
                  state_q <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               rsp_cause_q <= chk_cause;
               if (chk_cause != CAUSE_NONE) begin
                  rsp_fault_q   <= 1'b1;
                  rsp_paddr_q   <= '0;
                  fault_addr_q  <= vaddr_q;
                  fault_cause_q <= chk_cause;
                  state_q       <= ST_RSP;
               end else begin
                  rsp_fault_q <= 1'b0;
                  rsp_paddr_q <= paddr;
                  state_q     <= need_wb ? ST_WB : ST_RSP;
               end
            end
            ST_WB: begin
               if (mem_req_ready) state_q <= ST_RSP;
            end
            ST_RSP: begin
               if (rsp_ready) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req_valid = 1'b0;
      mem_req_write = 1'b0;
      mem_req_addr  = '0;
      mem_req_wdata = '0;
      case (state_q)
         ST_DIR_REQ: begin
            mem_req_valid = 1'b1;
            mem_req_addr  = dir_addr;
         end
         ST_LEAF_REQ: begin
            mem_req_valid = 1'b1;
            mem_req_addr  = leaf_addr;
         end
         ST_WB: begin
            mem_req_valid = 1'b1;
            mem_req_write = 1'b1;
            mem_req_addr  = leaf_addr;
            mem_req_wdata = leaf_next;
         end
         default: ;
      endcase
   end

   assign req_ready   = (state_q == ST_IDLE);
   assign rsp_valid   = (state_q == ST_RSP);
   assign rsp_fault   = rsp_fault_q;
   assign rsp_cause   = rsp_cause_q;
   assign rsp_paddr   = rsp_paddr_q;
   assign fault_addr  = fault_addr_q;
   assign fault_cause = fault_cause_q;

   // Guards on handshakes and results
   assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr)
                                && $stable(rsp_fault) && $stable(rsp_cause));

   assert_one_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
                                && $stable(mem_req_write) && $stable(mem_req_wdata));

   assert_fault_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> rsp_cause != 2'd0);

   assert_ok_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_fault |-> rsp_cause == 2'd0);

   assert_fault_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> fault_cause == rsp_cause && fault_addr == vaddr_q);

   assert_wb_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_write |-> mem_req_wdata[FLG_A] && mem_req_wdata[FLG_P]);

   assert_wb_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_write && write_q |-> mem_req_wdata[FLG_D]);

endmodule

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] root_base = 32'h0010_0000;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic        rsp_fault;
   logic [1:0]  rsp_cause;
   logic [31:0] rsp_paddr;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic        mem_req_write;
   logic [31:0] mem_req_addr;
   logic [31:0] mem_req_wdata;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_rdata = '0;
   logic [31:0] fault_addr;
   logic [1:0]  fault_cause;

   always #10 clk = ~clk;

   ptw_walker dut_i (
      .clk(clk), .rst_n(rst_n), .root_base(root_base),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_write(req_write), .req_user(req_user),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
      .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_rdata(mem_rsp_rdata), .fault_addr(fault_addr),
      .fault_cause(fault_cause)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Memory model
   logic [31:0] mem_model [logic [31:0]];
   int          wr_count = 0;

   function automatic logic [31:0] mrd(input logic [31:0] a);
      if (mem_model.exists(a)) return mem_model[a];
      return 32'h0;
   endfunction

   initial begin : mem_responder
      bit          rd_due = 1'b0;
      logic [31:0] rd_buf = '0;
      int          cyc = 0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (rd_due) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_rdata = rd_buf;
            rd_due        = 1'b0;
         end
         cyc++;
         mem_req_ready = (cyc % 3) != 0;
         if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
               mem_model[mem_req_addr] = mem_req_wdata;
               wr_count++;
            end else begin
               rd_buf = mrd(mem_req_addr);
               rd_due = 1'b1;
            end
         end
      end
   end

   // Scoreboard
   typedef struct {
      logic [31:0] vaddr;
      bit          fault;
      logic [1:0]  cause;
      logic [31:0] paddr;
      logic [31:0] leaf_addr;
      logic [31:0] leaf_exp;
      bit          leaf_chk;
      int          writes;
   } exp_t;

   exp_t        sb_q[$];
   logic [31:0] last_fault_addr = '0;
   logic [1:0]  last_fault_cause = '0;

   function automatic exp_t predict(input logic [31:0] va, input bit wr, input bit usr);
      exp_t        e;
      logic [31:0] de, te, nt;
      e.vaddr = va; e.fault = 1'b0; e.cause = 2'd0; e.paddr = '0;
      e.leaf_addr = '0; e.leaf_exp = '0; e.leaf_chk = 1'b0; e.writes = 0;
      de = mrd(root_base + {20'h0, va[31:22], 2'b00});
      if (!de[0]) begin
         e.fault = 1'b1; e.cause = 2'd1;
         return e;
      end
      e.leaf_addr = {de[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
      te = mrd(e.leaf_addr);
      e.leaf_chk = 1'b1;
      e.leaf_exp = te;
      if (!te[0]) begin e.fault = 1'b1; e.cause = 2'd1; return e; end
      if (wr && !(de[1] && te[1])) begin e.fault = 1'b1; e.cause = 2'd2; return e; end
      if (usr && !(de[2] && te[2])) begin e.fault = 1'b1; e.cause = 2'd3; return e; end
      nt = te | 32'h20 | (wr ? 32'h40 : 32'h0);
      e.leaf_exp = nt;
      e.writes   = (nt != te) ? 1 : 0;
      e.paddr    = {te[31:12], va[11:0]};
      return e;
   endfunction

   initial begin : monitor
      int cyc = 0;
      forever begin
         @(negedge clk);
         cyc++;
         rsp_ready = (cyc % 4) != 1;
         if (rsp_valid && rsp_ready) begin
            exp_t e;
            if (sb_q.size() == 0) begin
               chk(1'b0, "R9", "unexpected response", 32'd1, 32'd0);
            end else begin
               e = sb_q.pop_front();
               chk(rsp_fault == e.fault, e.fault ? "R3" : "R2", "fault flag",
                   {31'h0, rsp_fault}, {31'h0, e.fault});
               chk(rsp_cause == e.cause,
                   e.cause == 2'd2 ? "R4" : (e.cause == 2'd3 ? "R5" : "R3"),
                   "cause", {30'h0, rsp_cause}, {30'h0, e.cause});
               if (!e.fault)
                  chk(rsp_paddr == e.paddr, "R2", "paddr", rsp_paddr, e.paddr);
               chk(wr_count == e.writes, "R7", "write-back count",
                   wr_count, e.writes);
               if (e.leaf_chk)
                  chk(mrd(e.leaf_addr) == e.leaf_exp, "R6", "leaf entry in memory",
                      mrd(e.leaf_addr), e.leaf_exp);
               if (e.fault) begin
                  last_fault_addr  = e.vaddr;
                  last_fault_cause = e.cause;
               end
               chk(fault_addr == last_fault_addr, "R8", "fault_addr",
                   fault_addr, last_fault_addr);
               chk(fault_cause == last_fault_cause, "R8", "fault_cause",
                   {30'h0, fault_cause}, {30'h0, last_fault_cause});
            end
         end else if (rsp_valid) begin
            chk(req_ready == 1'b0, "R9", "req_ready while response pending",
                {31'h0, req_ready}, 32'h0);
         end
      end
   end

   task automatic walk(input logic [9:0] di, input logic [9:0] ti,
                       input logic [11:0] off, input bit wr, input bit usr);
      logic [31:0] va;
      va = {di, ti, off};
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      sb_q.push_back(predict(va, wr, usr));
      wr_count  = 0;
      req_vaddr = va;
      req_write = wr;
      req_user  = usr;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R9", "req_ready after accept", {31'h0, req_ready}, 32'h0);
      while (sb_q.size() != 0) @(negedge clk);
   endtask

   task automatic put(input logic [31:0] a, input logic [31:0] v);
      mem_model[a] = v;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : driver
      logic [31:0] lcg;
      logic [9:0]  dsel [5];
      logic [9:0]  tsel [6];
      dsel = '{10'd0, 10'd1, 10'd2, 10'd3, 10'h3FF};
      tsel = '{10'd0, 10'd1, 10'd2, 10'd3, 10'd4, 10'h3FF};

      // Directory at root_base, tables at 0x0020_x000
      put(32'h0010_0000 + 4*0,      32'h0020_0007);
      put(32'h0010_0000 + 4*1,      32'h0020_1003);
      put(32'h0010_0000 + 4*2,      32'h0020_2005);
      put(32'h0010_0000 + 4*3,      32'h0020_3000);
      put(32'h0010_0000 + 4*1023,   32'h0020_4007);
      put(32'h0020_0000 + 4*0,      32'h1234_5007);
      put(32'h0020_0000 + 4*1,      32'h0ABC_D005);
      put(32'h0020_0000 + 4*2,      32'h0055_5003);
      put(32'h0020_0000 + 4*3,      32'h0000_0000);
      put(32'h0020_0000 + 4*4,      32'h0777_7001);
      put(32'h0020_1000 + 4*0,      32'h0300_0007);
      put(32'h0020_2000 + 4*0,      32'h0400_0007);
      put(32'h0020_4000 + 4*1023,   32'hFFFF_F067);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(req_ready == 1'b1, "R11", "req_ready", {31'h0, req_ready}, 32'h1);
      chk(rsp_valid == 1'b0, "R11", "rsp_valid", {31'h0, rsp_valid}, 32'h0);
      chk(mem_req_valid == 1'b0, "R11", "mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
      chk(fault_addr == 32'h0, "R11", "fault_addr", fault_addr, 32'h0);
      chk(fault_cause == 2'd0, "R11", "fault_cause", {30'h0, fault_cause}, 32'h0);

      walk(10'd0, 10'd0, 12'h150, 1'b0, 1'b0);    // R1 R6 accessed set
      walk(10'd0, 10'd0, 12'h150, 1'b0, 1'b0);    // R7 no second write
      walk(10'd0, 10'd0, 12'hABC, 1'b1, 1'b1);    // R6 dirty set
      walk(10'd0, 10'd0, 12'h004, 1'b1, 1'b0);    // R7 nothing changes
      walk(10'd3, 10'd0, 12'h010, 1'b0, 1'b0);    // R3 directory absent
      walk(10'd0, 10'd3, 12'h020, 1'b0, 1'b0);    // R3 leaf absent
      walk(10'd0, 10'd1, 12'h030, 1'b1, 1'b0);    // R4 read-only leaf
      walk(10'd0, 10'd2, 12'h040, 1'b0, 1'b1);    // R5 kernel leaf
      walk(10'd0, 10'd4, 12'h050, 1'b1, 1'b1);    // R5 write cause wins
      walk(10'd2, 10'd0, 12'h060, 1'b1, 1'b0);    // R4 directory forbids write
      walk(10'd1, 10'd0, 12'h070, 1'b0, 1'b1);    // R5 directory forbids user
      walk(10'd0, 10'd1, 12'h080, 1'b0, 1'b1);    // R8 fault regs hold on success
      walk(10'h3FF, 10'h3FF, 12'hFFF, 1'b0, 1'b0); // R1 R2 top indices
      walk(10'h3FF, 10'h3FF, 12'h000, 1'b1, 1'b1); // R7 flags already set

      lcg = 32'h1357_9BDF;
      for (int i = 0; i < 40; i++) begin
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         walk(dsel[lcg[31:24] % 5], tsel[lcg[23:16] % 6], lcg[11:0],
              lcg[13], lcg[14]);
      end

      repeat (5) @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule